// File: doc/BRIEF.md
# Multibank Row-Register Hit/Miss Controller

This block sits in front of a cached DRAM core with four internal banks. Each bank has one row-wide cache register and a tag naming the row that register holds. The controller samples the row-enable strobe in the system clock domain. On each falling edge it decodes the control strobes into a cycle type and picks the bank from two non-adjacent row-address bits. It compares the rest of the row address against that bank's tag and issues one-cycle command pulses: fill the cache register from the array, write the array, write the cache register, or run an internal refresh.

The coherency policy works as follows. A write that hits updates both the array and the cache register. A write that misses goes to the array only and leaves the tag alone. During a write miss, and for a programmable recovery time after row enable is released, the output-enable qualifier is forced low.

The controller also recognises cache reads that arrive without a row-enable edge and reports the row they address. It tracks the start-up sequence that must finish before tags are trusted.

Top module: `rowreg_hitmiss_ctrl`

## Requirements
- R1: The bank index is {row_addr[9], row_addr[2]}. The tag is the remaining nine row bits. Each of the four banks keeps its own tag and valid bit.
- R2: After reset every bank is invalid, and any access to an invalid bank is a miss. A bank becomes valid only after eight legal row-enable cycles have been counted, followed by two reads to that bank with different tags. init_done_o rises once all four banks are valid.
- R3: A read (wr_rd=0) whose tag does not match a valid bank pulses miss_o and fill_o one cycle after the edge is seen, and loads the new tag into that bank.
- R4: A read whose tag matches a valid bank pulses hit_o without fill_o and leaves the tag unchanged.
- R5: A write (wr_rd=1, cl_n=1, we_n=1 at the edge) that hits pulses hit_o. Each later clock with cl_n=0 and we_n=0 while row enable is low pulses both arr_wr_o and cache_wr_o. out_en_o stays high throughout.
- R6: A write that misses pulses miss_o. Its strobes pulse arr_wr_o only, and that bank's tag is unchanged, so a later read of the previously cached row still hits.
- R7: After a write-miss edge, out_en_o and cache_rd_o are held low until RECOV_CYC clock edges have seen row enable high again. out_en_o is high in the following cycle.
- R8: A write strobe requires cl_n and we_n both low. A write cycle that ends with no strobe pulses row_rfsh_o when row enable rises.
- R9: rfsh_n=0 at the edge pulses rfsh_o whatever the state of sel_n, raises no error and changes no tag.
- R10: An edge with sel_n=1 and rfsh_n=1 is illegal. So is a write edge with cl_n or we_n low. Either pulses illegal_o only and is not counted as an initialization cycle.
- R11: With row enable high, sel_n=0, oe_n=0, we_n=1 and cl_n=0, cache_rd_o pulses. rd_row_o holds the row of the most recent row-enable read.
- R12: During reset all command pulses, init_done_o and rd_row_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| re_n | input | 1 | Row enable, active low; falling edge starts a cycle |
| sel_n | input | 1 | Chip select, active low |
| wr_rd | input | 1 | Cycle direction: 1 write, 0 read |
| rfsh_n | input | 1 | Internal-refresh request, active low |
| cl_n | input | 1 | Column latch strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_addr | input | ROW_W | Row address sampled at the row-enable edge |
| hit_o | output | 1 | Tag match pulse |
| miss_o | output | 1 | Tag mismatch pulse |
| fill_o | output | 1 | Load row from array into cache register |
| arr_wr_o | output | 1 | Write strobe to the array |
| cache_wr_o | output | 1 | Write strobe to the cache register |
| row_rfsh_o | output | 1 | Write cycle closed without a strobe (row refresh) |
| rfsh_o | output | 1 | Internal refresh command |
| illegal_o | output | 1 | Illegal-mode error pulse |
| out_en_o | output | 1 | Qualified output-driver enable |
| cache_rd_o | output | 1 | Cache read without row enable |
| rd_row_o | output | ROW_W | Row of the latest row-enable read |
| init_done_o | output | 1 | All banks initialized |

## Verification
Some properties are checked on every cycle. Hit and miss are never reported together, and a fill only appears with a read miss. A cache write never occurs without an array write, and an illegal edge produces no other command. A write-miss edge always drops the output qualifier. Valid bits never fall, and a hit never alters a tag. Other behaviour can only be shown by the bench's scenarios, because it depends on history. This covers the exact point at which each bank turns valid, and the fact that a write miss leaves a later read still hitting. It also covers the exact length of the recovery window and the row reported for cache reads taken without row enable.

// File: rtl/rrc_pkg.sv
// Shared types for the row-register hit/miss controller.
// Assumes: one cycle type is decoded per row-enable falling edge.
package rrc_pkg;
    typedef enum logic [1:0] {
        CYC_READ    = 2'd0,
        CYC_WRITE   = 2'd1,
        CYC_REFRESH = 2'd2,
        CYC_ILLEGAL = 2'd3
    } cyc_kind_e;
endpackage

// File: rtl/rrc_mode_decode.sv
// Decodes the control strobes present at a row-enable falling edge
// into a cycle type. Purely combinational; the caller gates it with the edge.
// Assumes: refresh takes priority, then chip select, then direction.
module rrc_mode_decode
    import rrc_pkg::*;
(
    input  logic      sel_n,
    input  logic      wr_rd,
    input  logic      rfsh_n,
    input  logic      cl_n,
    input  logic      we_n,
    output cyc_kind_e kind
);
    // Priority decode of the strobe pattern.
    always_comb begin
        if (!rfsh_n)
            kind = CYC_REFRESH;
        else if (sel_n)
            kind = CYC_ILLEGAL;
        else if (!wr_rd)
            kind = CYC_READ;
        else if (cl_n && we_n)
            kind = CYC_WRITE;
        else
            kind = CYC_ILLEGAL;
    end
endmodule

// File: rtl/rrc_tag_bank.sv
// Per-bank last-row tags with valid tracking.
// A read loads the tag on a miss. Once warm, a bank turns valid on the
// second read whose tag differs from the stored one.
// Assumes: rd_evt is a one-cycle pulse at a legal read edge.
module rrc_tag_bank #(
    parameter int TAG_W = 9,
    parameter int BW    = 2,
    localparam int NB   = 1 << BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    bank,
    input  logic [TAG_W-1:0] tag,
    input  logic             rd_evt,
    input  logic             warm,
    output logic             hit,
    output logic             all_valid
);
    logic [NB-1:0][TAG_W-1:0] tags;
    logic [NB-1:0]            valid;
    logic [NB-1:0]            seen;

    // Lookup against the selected bank.
    always_comb begin
        hit       = valid[bank] && (tags[bank] == tag);
        all_valid = &valid;
    end

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic sel_me;
        assign sel_me = rd_evt && (bank == BW'(g));

        // Tag, seen and valid update for bank g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[g]  <= '0;
                valid[g] <= 1'b0;
                seen[g]  <= 1'b0;
            end else if (sel_me) begin
                if (!(valid[g] && tags[g] == tag))
                    tags[g] <= tag;
                if (warm && !valid[g]) begin
                    if (!seen[g])
                        seen[g] <= 1'b1;
                    else if (tags[g] != tag)
                        valid[g] <= 1'b1;
                end
            end
        end

        assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$fell(valid[g]));
        assert_hit_keeps_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_me && hit) |=> $stable(tags[g]));
    end
endmodule

// File: rtl/rrc_read_inhibit.sv
// Recovery timer for the output inhibit after a write miss.
// Holds inhibit while row enable is low, then for RECOV_CYC edges with
// row enable high.
// Assumes: start is a one-cycle pulse at a write-miss edge.
module rrc_read_inhibit #(
    parameter int RECOV_CYC = 4,
    localparam int CW       = $clog2(RECOV_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic re_high,
    output logic inhibit
);
    logic [CW-1:0] cnt;

    // Arm on start, count down only while row enable is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            inhibit <= 1'b1;
            cnt     <= CW'(RECOV_CYC);
        end else if (inhibit && re_high) begin
            if (cnt == '0)
                inhibit <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assert_inhibit_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !re_high) |=> inhibit);
endmodule

// File: rtl/rowreg_hitmiss_ctrl.sv
// Top of the row-register hit/miss controller. It detects row-enable
// falling edges, splits the row address into bank index and tag, and
// issues registered one-cycle command pulses.
// Assumes: all strobes are synchronous to clk; row_addr is stable at the edge.
module rowreg_hitmiss_ctrl
    import rrc_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int BANK_LO   = 2,
    parameter int BANK_HI   = 9,
    parameter int INIT_CYC  = 8,
    parameter int RECOV_CYC = 4,
    localparam int BW       = 2,
    localparam int TAG_W    = ROW_W - BW,
    localparam int ICW      = $clog2(INIT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re_n,
    input  logic             sel_n,
    input  logic             wr_rd,
    input  logic             rfsh_n,
    input  logic             cl_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] row_addr,
    output logic             hit_o,
    output logic             miss_o,
    output logic             fill_o,
    output logic             arr_wr_o,
    output logic             cache_wr_o,
    output logic             row_rfsh_o,
    output logic             rfsh_o,
    output logic             illegal_o,
    output logic             out_en_o,
    output logic             cache_rd_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic             init_done_o
);
    logic             re_q, fall, rise;
    cyc_kind_e        kind;
    logic [BW-1:0]    bank;
    logic [TAG_W-1:0] tag;
    logic             hit, all_valid, warm, rd_evt, wmiss_start;
    logic             wr_cyc_q, wr_hit_q, strobed_q, inh;
    logic [ICW-1:0]   init_cnt;

    // Row-enable edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) re_q <= 1'b1;
        else        re_q <= re_n;
    end
    assign fall = re_q && !re_n;
    assign rise = !re_q && re_n;

    // Split the row address into bank index and tag.
    always_comb begin
        int j;
        j    = 0;
        tag  = '0;
        bank = {row_addr[BANK_HI], row_addr[BANK_LO]};
        for (int i = 0; i < ROW_W; i++) begin
            if (i != BANK_LO && i != BANK_HI) begin
                tag[j] = row_addr[i];
                j++;
            end
        end
    end

    rrc_mode_decode u_dec (
        .sel_n(sel_n), .wr_rd(wr_rd), .rfsh_n(rfsh_n),
        .cl_n(cl_n), .we_n(we_n), .kind(kind)
    );

    assign warm        = (init_cnt == ICW'(INIT_CYC));
    assign rd_evt      = fall && (kind == CYC_READ);
    assign wmiss_start = fall && (kind == CYC_WRITE) && !hit;

    rrc_tag_bank #(.TAG_W(TAG_W), .BW(BW)) u_tags (
        .clk(clk), .rst_n(rst_n), .bank(bank), .tag(tag),
        .rd_evt(rd_evt), .warm(warm), .hit(hit), .all_valid(all_valid)
    );

    rrc_read_inhibit #(.RECOV_CYC(RECOV_CYC)) u_inh (
        .clk(clk), .rst_n(rst_n), .start(wmiss_start),
        .re_high(re_n), .inhibit(inh)
    );

    // Saturating count of legal row-enable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_cnt <= '0;
        else if (fall && kind != CYC_ILLEGAL && !warm)
            init_cnt <= init_cnt + 1'b1;
    end

    // Command pulses and write-cycle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o <= 1'b0;      miss_o <= 1'b0;     fill_o <= 1'b0;
            arr_wr_o <= 1'b0;   cache_wr_o <= 1'b0; row_rfsh_o <= 1'b0;
            rfsh_o <= 1'b0;     illegal_o <= 1'b0;  cache_rd_o <= 1'b0;
            rd_row_o <= '0;     init_done_o <= 1'b0;
            wr_cyc_q <= 1'b0;   wr_hit_q <= 1'b0;   strobed_q <= 1'b0;
        end else begin
            hit_o      <= fall && (kind == CYC_READ || kind == CYC_WRITE) && hit;
            miss_o     <= fall && (kind == CYC_READ || kind == CYC_WRITE) && !hit;
            fill_o     <= rd_evt && !hit;
            rfsh_o     <= fall && (kind == CYC_REFRESH);
            illegal_o  <= fall && (kind == CYC_ILLEGAL);
            init_done_o <= all_valid;
            arr_wr_o   <= wr_cyc_q && !re_n && !cl_n && !we_n;
            cache_wr_o <= wr_cyc_q && wr_hit_q && !re_n && !cl_n && !we_n;
            cache_rd_o <= re_n && !sel_n && !oe_n && !cl_n && we_n && !inh;
            row_rfsh_o <= rise && wr_cyc_q && !strobed_q;
            if (rd_evt)
                rd_row_o <= row_addr;
            if (fall && kind == CYC_WRITE) begin
                wr_cyc_q  <= 1'b1;
                wr_hit_q  <= hit;
                strobed_q <= 1'b0;
            end else if (rise) begin
                wr_cyc_q <= 1'b0;
            end else if (wr_cyc_q && !re_n && !cl_n && !we_n) begin
                strobed_q <= 1'b1;
            end
        end
    end

    // Output-driver qualifier.
    assign out_en_o = !sel_n && !oe_n && !inh;

    assert_hit_miss_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && miss_o));
    assert_fill_is_read_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o |-> (miss_o && !wr_cyc_q));
    assert_cache_wr_with_arr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_o |-> arr_wr_o);
    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(hit_o || miss_o || rfsh_o || fill_o));
    assert_wmiss_blocks_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_o && wr_cyc_q && !wr_hit_q) |-> !out_en_o);
    assert_strobe_both_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_o |-> ($past(!cl_n) && $past(!we_n)));
endmodule

// File: tb/rowreg_hitmiss_ctrl_bench.sv
`timescale 1ns/1ps
module rowreg_hitmiss_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic re_n = 1'b1, sel_n = 1'b1, wr_rd = 1'b0, rfsh_n = 1'b1;
    logic cl_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] row_addr = '0;
    logic hit_o, miss_o, fill_o, arr_wr_o, cache_wr_o, row_rfsh_o, rfsh_o;
    logic illegal_o, out_en_o, cache_rd_o, init_done_o;
    logic [10:0] rd_row_o;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rowreg_hitmiss_ctrl u_rowreg_hitmiss_ctrl (
        .clk(clk), .rst_n(rst_n), .re_n(re_n), .sel_n(sel_n), .wr_rd(wr_rd),
        .rfsh_n(rfsh_n), .cl_n(cl_n), .we_n(we_n), .oe_n(oe_n),
        .row_addr(row_addr), .hit_o(hit_o), .miss_o(miss_o), .fill_o(fill_o),
        .arr_wr_o(arr_wr_o), .cache_wr_o(cache_wr_o), .row_rfsh_o(row_rfsh_o),
        .rfsh_o(rfsh_o), .illegal_o(illegal_o), .out_en_o(out_en_o),
        .cache_rd_o(cache_rd_o), .rd_row_o(rd_row_o), .init_done_o(init_done_o)
    );

    // Row address from bank index (bits 9 and 2) and a 9-bit tag.
    function automatic logic [10:0] mk_row(input logic [1:0] b, input logic [8:0] t);
        logic [10:0] r;
        int j;
        j = 0;
        r = '0;
        for (int i = 0; i < 11; i++) begin
            if (i == 2)      r[i] = b[0];
            else if (i == 9) r[i] = b[1];
            else begin r[i] = t[j]; j++; end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive a row-enable falling edge, then sample the pulses.
    task automatic edge_fall(input logic s, input logic w, input logic rf,
                             input logic c, input logic we, input logic [10:0] row);
        sel_n = s; wr_rd = w; rfsh_n = rf; cl_n = c; we_n = we; row_addr = row;
        re_n = 1'b0;
        tick();
    endtask

    task automatic release_re();
        re_n = 1'b1; cl_n = 1'b1; we_n = 1'b1; rfsh_n = 1'b1;
        tick();
    endtask

    task automatic do_read(input logic [10:0] row, input bit exp_hit, input string req);
        edge_fall(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, row);
        check({req, " hit"}, hit_o, exp_hit);
        check({req, " miss"}, miss_o, !exp_hit);
        check({req, " fill"}, fill_o, !exp_hit);
        release_re();
    endtask

    task automatic t_reset_R12();
        check("R12 hit", hit_o, 0);
        check("R12 miss", miss_o, 0);
        check("R12 init_done", init_done_o, 0);
        check("R12 rd_row", rd_row_o, 0);
        check("R12 illegal", illegal_o, 0);
    endtask

    task automatic t_illegal_R10();
        edge_fall(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, mk_row(0, 9'h003));
        check("R10 deselected illegal", illegal_o, 1);
        check("R10 deselected no miss", miss_o, 0);
        release_re();
        edge_fall(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, mk_row(0, 9'h003));
        check("R10 write strobe at edge illegal", illegal_o, 1);
        check("R10 no hit", hit_o, 0);
        release_re();
    endtask

    task automatic t_warmup_R9();
        for (int k = 0; k < 8; k++) begin
            edge_fall(k[0], 1'b0, 1'b0, 1'b1, 1'b1, '0);
            check("R9 refresh pulse", rfsh_o, 1);
            check("R9 refresh not illegal", illegal_o, 0);
            release_re();
        end
    endtask

    task automatic t_bank_init_R2();
        do_read(mk_row(0, 9'h1A5), 1'b0, "R2 first read");
        do_read(mk_row(0, 9'h1A5), 1'b0, "R2 same row still invalid");
        do_read(mk_row(0, 9'h05A), 1'b0, "R2 second distinct read");
        do_read(mk_row(0, 9'h05A), 1'b1, "R4 hit after valid");
        check("R2 not done yet", init_done_o, 0);
        do_read(mk_row(1, 9'h011), 1'b0, "R1 bank1 a");
        do_read(mk_row(1, 9'h022), 1'b0, "R1 bank1 b");
        do_read(mk_row(2, 9'h033), 1'b0, "R1 bank2 a");
        do_read(mk_row(2, 9'h044), 1'b0, "R1 bank2 b");
        do_read(mk_row(3, 9'h055), 1'b0, "R1 bank3 a");
        do_read(mk_row(3, 9'h066), 1'b0, "R1 bank3 b");
        tick();
        check("R2 init done", init_done_o, 1);
    endtask

    task automatic t_read_R3_R4();
        do_read(mk_row(1, 9'h022), 1'b1, "R4 bank1 hit");
        do_read(mk_row(2, 9'h0F0), 1'b0, "R3 bank2 miss");
        do_read(mk_row(2, 9'h0F0), 1'b1, "R3 new tag now hits");
        do_read(mk_row(1, 9'h022), 1'b1, "R1 bank1 unaffected by bank2");
    endtask

    task automatic t_cache_read_R11();
        sel_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; cl_n = 1'b0;
        tick();
        check("R11 cache read", cache_rd_o, 1);
        check("R11 read row", rd_row_o, mk_row(1, 9'h022));
        cl_n = 1'b1;
        tick();
        check("R11 no strobe no read", cache_rd_o, 0);
    endtask

    task automatic t_write_hit_R5();
        edge_fall(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, mk_row(0, 9'h05A));
        check("R5 write hit", hit_o, 1);
        check("R5 out enabled", out_en_o, 1);
        cl_n = 1'b0; we_n = 1'b0;
        tick();
        check("R5 array write", arr_wr_o, 1);
        check("R5 cache write", cache_wr_o, 1);
        cl_n = 1'b1; we_n = 1'b1;
        tick();
        check("R5 strobe ends", arr_wr_o, 0);
        release_re();
        check("R8 strobed cycle no row refresh", row_rfsh_o, 0);
    endtask

    task automatic t_no_strobe_R8();
        edge_fall(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, mk_row(3, 9'h066));
        cl_n = 1'b0; we_n = 1'b1;
        tick();
        check("R8 column only no write", arr_wr_o, 0);
        cl_n = 1'b1;
        tick();
        release_re();
        check("R8 row refresh on release", row_rfsh_o, 1);
    endtask

    task automatic t_write_miss_R6_R7();
        edge_fall(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, mk_row(1, 9'h1FF));
        check("R6 write miss", miss_o, 1);
        check("R6 no fill", fill_o, 0);
        check("R7 out inhibited at edge", out_en_o, 0);
        cl_n = 1'b0; we_n = 1'b0;
        tick();
        check("R6 array write", arr_wr_o, 1);
        check("R6 no cache write", cache_wr_o, 0);
        we_n = 1'b1;
        tick();
        check("R7 cache read blocked", cache_rd_o, 0);
        cl_n = 1'b1;
        re_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R7 inhibit window", out_en_o, 0);
        end
        tick();
        check("R7 out enabled after window", out_en_o, 1);
        do_read(mk_row(1, 9'h022), 1'b1, "R6 tag kept after write miss");
    endtask

    task automatic t_refresh_keeps_R9();
        edge_fall(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, mk_row(3, 9'h0AA));
        check("R9 selected refresh", rfsh_o, 1);
        check("R9 no miss", miss_o, 0);
        release_re();
        do_read(mk_row(3, 9'h066), 1'b1, "R9 tag unchanged by refresh");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        t_reset_R12();
        rst_n = 1'b1;
        tick();
        t_illegal_R10();
        t_warmup_R9();
        check("R2 not done after warmup", init_done_o, 0);
        t_bank_init_R2();
        t_read_R3_R4();
        t_cache_read_R11();
        t_write_hit_R5();
        t_no_strobe_R8();
        t_write_miss_R6_R7();
        t_refresh_keeps_R9();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule